// File: doc/BRIEF.md
# Paged Host Register Window

This block is the host-facing register window of a network controller. The host reaches it through a small I/O range with 16-bit accesses. The four words at the bottom of the range are visible whatever page is selected: the identification word, the page/chip-ID word, the set/clear option word and the command word. The words above them are banked: each of the eight pages has its own small set of read/write words, and the page select picks which set answers.

The option word does not store written data. Each byte lane has a control bit (bit 0 for the low byte, bit 8 for the high byte). When the control bit is 1, every other bit written as 1 in that lane is set. When it is 0, every such bit is cleared. Bits written as 0 keep their value. Two bits of the option word drive outputs: a controller reset level, which also gives a one-cycle start pulse on its rising edge, and the memory-mapped enable. The command word holds request bits that the host raises and the hardware drops on completion. It also holds a busy flag for a timed EEPROM load.

Top module: `hostwin_regs`

## Requirements
- R1: After reset the page is 0, the option and command words read 0x0000, ctrl_reset_n is 0, and mmap_active, adv_req, tx_req, ee_busy and ctrl_reset_pulse are all 0.
- R2: Reading offset 0x00 on any page returns 0x4850. A write to 0x00 stores nothing; in the same cycle it shows trace_valid=1 and trace_data equal to the written word.
- R3: A write to offset 0x02 selects page wdata[2:0] from the next cycle. Reading 0x02 returns CHIP_ID[15:4] in bits 15:4, 0 in bit 3, and the page in bits 2:0.
- R4: Offsets 0x00 to 0x07 give the same contents on every page.
- R5: A write to the option word at 0x04 sets or clears bits 7:1 according to wdata[0] (1 sets, 0 clears) and bits 15:9 according to wdata[8]. Only bits written as 1 are affected. Bits 0 and 8 always read 0.
- R6: ctrl_reset_n follows option bit 1 (0 holds the controller in reset). ctrl_reset_pulse is 1 for exactly one cycle, the first cycle in which bit 1 reads 1 after reading 0.
- R7: mmap_active is 1 exactly when option bit 13 (map disable) is 0 and option bit 6 (memory enable) is 1.
- R8: Writing 1 to command bit 2 or bit 1 at 0x06 sets adv_req or tx_req respectively. Writing 0 to these bits has no effect. A one-cycle adv_done or tx_done clears the matching bit on the next edge. The bits read back at positions 2 and 1.
- R9: Writing 1 to command bit 6 while idle starts an EEPROM load. ee_busy, and bit 6 of the command word, then read 1 for exactly EE_LOAD_CYCLES cycles. A start written while the load is running is ignored.
- R10: Each page holds BANK_WORDS read/write words at offsets 0x08, 0x0A and upward. A word written on one page does not change the same offset on another page.
- R11: Reads at odd offsets, or at even offsets above the last banked word, return 0x0000.
- R12: Command bit 7 (priority transmit) is a plain read/write bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Write strobe, one word per cycle |
| host_addr | input | ADDR_W | Byte offset inside the window |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| trace_valid | output | 1 | Write to the debug trace word in progress |
| trace_data | output | 16 | Word written to the trace port |
| ctrl_reset_n | output | 1 | Controller reset level, 0 holds reset |
| ctrl_reset_pulse | output | 1 | One-cycle pulse when the controller leaves reset |
| mmap_active | output | 1 | Memory-mapped access enabled |
| adv_req | output | 1 | Advance-to-next-packet request pending |
| adv_done | input | 1 | Hardware finished the advance |
| tx_req | output | 1 | Transmit command pending |
| tx_done | input | 1 | Hardware finished the transmit command |
| ee_busy | output | 1 | EEPROM load in progress |

## Verification
The assertions take several things for granted. The hardware raises a completion strobe only while the matching request is pending, and for one cycle. An EEPROM load can start only from a host write. Reads of the option word are expected to agree with the memory-map output in the same cycle.

The stimulus respects these points. It pulses tx_done and adv_done for a single cycle, and only after the host has set the request. It holds host_wr low outside its write tasks. It never pulses a completion strobe in the same cycle as a host write that sets the same request.

// File: rtl/hostwin_pkg.sv
// Shared constants for the paged host register window: word indices of the
// fixed words and bit positions inside the option and command words.
package hostwin_pkg;
    localparam int          WORD_W      = 16;
    localparam logic [15:0] HWID_VALUE  = 16'h4850;
    // word indices (byte offset / 2)
    localparam int          W_ID        = 0;
    localparam int          W_PAGE      = 1;
    localparam int          W_OPT1      = 2;
    localparam int          W_OPT3      = 3;
    localparam int          W_BANK0     = 4;
    // option word bits
    localparam int          OPT1_HWRST  = 1;
    localparam int          OPT1_MEMEN  = 6;
    localparam int          OPT1_MAPDIS = 13;
    // command word bits
    localparam int          OPT3_TXCMD  = 1;
    localparam int          OPT3_ADV    = 2;
    localparam int          OPT3_EELOAD = 6;
    localparam int          OPT3_PRIO   = 7;
endpackage

// File: rtl/hostwin_opt1.sv
// Option word with masked set/clear writes.
// Each byte lane has a control bit (its lowest bit). A write sets (control=1)
// or clears (control=0) every other bit of the lane written as 1.
// Assumes: wr is a single-cycle strobe already qualified by the address.
module hostwin_opt1 (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [15:0] wdata,
    output logic [15:0] value
);
    localparam int LANES = 2;

    for (genvar b = 0; b < LANES; b++) begin : g_lane
        logic [6:0] lane_q;
        logic       set_mode;
        logic [6:0] mask;

        assign set_mode = wdata[b*8];
        assign mask     = wdata[b*8+1 +: 7];

        // lane update: OR in the mask when setting, AND it out when clearing
        always_ff @(posedge clk) begin
            if (!rst_n)
                lane_q <= '0;
            else if (wr)
                lane_q <= set_mode ? (lane_q | mask) : (lane_q & ~mask);
        end

        assign value[b*8 +: 8] = {lane_q, 1'b0};
    end
endmodule

// File: rtl/hostwin_cmd.sv
// Command word: a priority bit, two self-clearing request bits and the
// EEPROM-load busy flag, which is timed by a down-counter.
// Assumes: wr is already qualified by the address; done strobes last one cycle.
module hostwin_cmd #(
    parameter int EE_LOAD_CYCLES = 30000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic        wr_prio,
    input  logic        wr_ee,
    input  logic        wr_adv,
    input  logic        wr_tx,
    input  logic        adv_done,
    input  logic        tx_done,
    output logic [15:0] value,
    output logic        adv_req,
    output logic        tx_req,
    output logic        ee_busy
);
    localparam int CNT_W = (EE_LOAD_CYCLES > 1) ? $clog2(EE_LOAD_CYCLES) : 1;

    logic             prio_q, adv_q, tx_q, busy_q;
    logic [CNT_W-1:0] cnt_q;

    // plain read/write priority bit
    always_ff @(posedge clk) begin
        if (!rst_n)  prio_q <= 1'b0;
        else if (wr) prio_q <= wr_prio;
    end

    // request bits: a host write of 1 sets, a completion strobe clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            adv_q <= 1'b0;
            tx_q  <= 1'b0;
        end else begin
            if (wr && wr_adv)  adv_q <= 1'b1;
            else if (adv_done) adv_q <= 1'b0;
            if (wr && wr_tx)   tx_q  <= 1'b1;
            else if (tx_done)  tx_q  <= 1'b0;
        end
    end

    // EEPROM load timer: busy for exactly EE_LOAD_CYCLES cycles
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (!busy_q) begin
            if (wr && wr_ee) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(EE_LOAD_CYCLES - 1);
            end
        end else if (cnt_q == '0) begin
            busy_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign value   = {8'h00, prio_q, busy_q, 3'b000, adv_q, tx_q, 1'b0};
    assign adv_req = adv_q;
    assign tx_req  = tx_q;
    assign ee_busy = busy_q;
endmodule

// File: rtl/hostwin_bank.sv
// Banked storage: PAGES x BANK_WORDS read/write words. Only the current page
// is reachable.
// Assumes: word_sel < BANK_WORDS whenever hit is 1.
module hostwin_bank #(
    parameter int PAGES      = 8,
    parameter int BANK_WORDS = 4,
    localparam int PAGE_W    = $clog2(PAGES),
    localparam int WIDX_W    = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              hit,
    input  logic [PAGE_W-1:0] page_sel,
    input  logic [WIDX_W-1:0] word_sel,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata
);
    localparam int CELLS = PAGES * BANK_WORDS;
    localparam int IDX_W = (CELLS > 1) ? $clog2(CELLS) : 1;

    logic [15:0]      cells [CELLS];
    logic [IDX_W-1:0] rd_idx;

    for (genvar p = 0; p < PAGES; p++) begin : g_page
        for (genvar w = 0; w < BANK_WORDS; w++) begin : g_word
            logic [15:0] cell_q;

            // one banked word, written only when page and word both match
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cell_q <= '0;
                else if (wr && hit && page_sel == PAGE_W'(p) && word_sel == WIDX_W'(w))
                    cell_q <= wdata;
            end

            assign cells[p*BANK_WORDS + w] = cell_q;
        end
    end

    assign rd_idx = IDX_W'(int'(page_sel) * BANK_WORDS + int'(word_sel));
    assign rdata  = hit ? cells[rd_idx] : 16'h0000;
endmodule

// File: rtl/hostwin_regs.sv
// Paged host register window (top). It decodes byte offsets into the fixed
// words and the banked words, muxes read data, forwards trace writes, and
// derives the controller reset pulse and the memory-map enable.
// Assumes: 16-bit accesses at even offsets, and PAGES <= 8 so that the page
// fits under the chip-ID field.
module hostwin_regs #(
    parameter logic [15:0] CHIP_ID        = 16'h5370,
    parameter int          PAGES          = 8,
    parameter int          BANK_WORDS     = 4,
    parameter int          ADDR_W         = 6,
    parameter int          EE_LOAD_CYCLES = 30000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              trace_valid,
    output logic [15:0]       trace_data,
    output logic              ctrl_reset_n,
    output logic              ctrl_reset_pulse,
    output logic              mmap_active,
    output logic              adv_req,
    input  logic              adv_done,
    output logic              tx_req,
    input  logic              tx_done,
    output logic              ee_busy
);
    import hostwin_pkg::*;

    localparam int PAGE_W = $clog2(PAGES);
    localparam int WA_W   = ADDR_W - 1;
    localparam int WIDX_W = (BANK_WORDS > 1) ? $clog2(BANK_WORDS) : 1;

    logic [WA_W-1:0]   word_addr;
    logic              even;
    logic              sel_id, sel_page, sel_opt1, sel_opt3, sel_bank;
    logic [WIDX_W-1:0] bank_widx;
    logic [PAGE_W-1:0] page_q;
    logic [15:0]       opt1_val, opt3_val, bank_rd;
    logic              hwrst_prev_q;

    // address decode
    assign word_addr = host_addr[ADDR_W-1:1];
    assign even      = ~host_addr[0];
    assign sel_id    = even && int'(word_addr) == W_ID;
    assign sel_page  = even && int'(word_addr) == W_PAGE;
    assign sel_opt1  = even && int'(word_addr) == W_OPT1;
    assign sel_opt3  = even && int'(word_addr) == W_OPT3;
    assign sel_bank  = even && int'(word_addr) >= W_BANK0
                            && int'(word_addr) <  W_BANK0 + BANK_WORDS;
    assign bank_widx = WIDX_W'(word_addr - WA_W'(W_BANK0));

    // page select register
    always_ff @(posedge clk) begin
        if (!rst_n)                   page_q <= '0;
        else if (host_wr && sel_page) page_q <= host_wdata[PAGE_W-1:0];
    end

    hostwin_opt1 u_opt1 (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (host_wr && sel_opt1),
        .wdata (host_wdata),
        .value (opt1_val)
    );

    hostwin_cmd #(.EE_LOAD_CYCLES(EE_LOAD_CYCLES)) u_cmd (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr && sel_opt3),
        .wr_prio  (host_wdata[OPT3_PRIO]),
        .wr_ee    (host_wdata[OPT3_EELOAD]),
        .wr_adv   (host_wdata[OPT3_ADV]),
        .wr_tx    (host_wdata[OPT3_TXCMD]),
        .adv_done (adv_done),
        .tx_done  (tx_done),
        .value    (opt3_val),
        .adv_req  (adv_req),
        .tx_req   (tx_req),
        .ee_busy  (ee_busy)
    );

    hostwin_bank #(.PAGES(PAGES), .BANK_WORDS(BANK_WORDS)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (host_wr),
        .hit      (sel_bank),
        .page_sel (page_q),
        .word_sel (bank_widx),
        .wdata    (host_wdata),
        .rdata    (bank_rd)
    );

    // read mux, zero for anything unmapped
    always_comb begin
        host_rdata = 16'h0000;
        if (sel_id)        host_rdata = HWID_VALUE;
        else if (sel_page) host_rdata = {CHIP_ID[15:4], 4'b0000} | 16'(page_q);
        else if (sel_opt1) host_rdata = opt1_val;
        else if (sel_opt3) host_rdata = opt3_val;
        else if (sel_bank) host_rdata = bank_rd;
    end

    // edge memory for the controller reset release
    always_ff @(posedge clk) begin
        if (!rst_n) hwrst_prev_q <= 1'b0;
        else        hwrst_prev_q <= opt1_val[OPT1_HWRST];
    end

    assign trace_valid      = host_wr && sel_id;
    assign trace_data       = host_wdata;
    assign ctrl_reset_n     = opt1_val[OPT1_HWRST];
    assign ctrl_reset_pulse = opt1_val[OPT1_HWRST] & ~hwrst_prev_q;
    assign mmap_active      = ~opt1_val[OPT1_MAPDIS] & opt1_val[OPT1_MEMEN];
endmodule

// File: rtl/hostwin_regs_chk.sv
// Checker for hostwin_regs, attached by bind. It relates the ports over time
// and times the EEPROM load window with its own counter.
module hostwin_regs_chk #(
    parameter logic [15:0] CHIP_ID        = 16'h5370,
    parameter int          ADDR_W         = 6,
    parameter int          EE_LOAD_CYCLES = 30000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [ADDR_W-1:0] host_addr,
    input logic [15:0]       host_rdata,
    input logic              ctrl_reset_n,
    input logic              ctrl_reset_pulse,
    input logic              mmap_active,
    input logic              adv_req,
    input logic              adv_done,
    input logic              tx_req,
    input logic              tx_done,
    input logic              ee_busy
);
    localparam int CW = $clog2(EE_LOAD_CYCLES + 1) + 1;
    logic [CW-1:0] busy_run_q;

    // length of the current busy run, seen one cycle late
    always_ff @(posedge clk) begin
        if (!rst_n || !ee_busy) busy_run_q <= '0;
        else                    busy_run_q <= busy_run_q + 1'b1;
    end

    assert_id_const_R2: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(0) |-> host_rdata == 16'h4850);
    assert_chipid_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(2) |-> host_rdata[15:3] == {CHIP_ID[15:4], 1'b0});
    assert_ctl_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(4) |-> (!host_rdata[0] && !host_rdata[8]));
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset_pulse |=> !ctrl_reset_pulse);
    assert_pulse_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctrl_reset_n) |-> ctrl_reset_pulse);
    assert_pulse_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_reset_pulse |-> ctrl_reset_n);
    assert_mmap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_addr == ADDR_W'(4) |-> mmap_active == (!host_rdata[13] && host_rdata[6]));
    assert_tx_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_req) |-> $past(tx_done));
    assert_adv_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adv_req) |-> $past(adv_done));
    assert_ee_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ee_busy) |-> $past(host_wr));
    assert_ee_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ee_busy |-> busy_run_q < CW'(EE_LOAD_CYCLES));
    assert_ee_length_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ee_busy) |-> busy_run_q == CW'(EE_LOAD_CYCLES));
endmodule

bind hostwin_regs hostwin_regs_chk #(
    .CHIP_ID(CHIP_ID), .ADDR_W(ADDR_W), .EE_LOAD_CYCLES(EE_LOAD_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_rdata(host_rdata), .ctrl_reset_n(ctrl_reset_n),
    .ctrl_reset_pulse(ctrl_reset_pulse), .mmap_active(mmap_active),
    .adv_req(adv_req), .adv_done(adv_done), .tx_req(tx_req), .tx_done(tx_done),
    .ee_busy(ee_busy)
);

// File: tb/sim_hostwin_regs.sv
// Self-checking bench: a vector table for the register map, then directed
// tests for reset, trace, reset pulse, memory map, commands and EEPROM load.
module sim_hostwin_regs;
    localparam int EE_N = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [5:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        trace_valid, ctrl_reset_n, ctrl_reset_pulse, mmap_active;
    logic [15:0] trace_data;
    logic        adv_req, tx_req, ee_busy;
    logic        adv_done = 1'b0, tx_done = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #10 clk = ~clk;   // 50 MHz

    hostwin_regs #(.EE_LOAD_CYCLES(EE_N)) u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .trace_valid(trace_valid), .trace_data(trace_data),
        .ctrl_reset_n(ctrl_reset_n), .ctrl_reset_pulse(ctrl_reset_pulse),
        .mmap_active(mmap_active), .adv_req(adv_req), .adv_done(adv_done),
        .tx_req(tx_req), .tx_done(tx_done), .ee_busy(ee_busy)
    );

    // {write?, write offset, write data, read offset, expected, requirement no.}
    localparam int NV = 16;
    localparam logic [48:0] VEC [NV] = '{
        {1'b1, 6'h02, 16'h0003, 6'h02, 16'h5373, 4'd3},  // R3 page 3
        {1'b1, 6'h08, 16'hA5A5, 6'h08, 16'hA5A5, 4'd10}, // R10 bank write
        {1'b1, 6'h02, 16'h0005, 6'h08, 16'h0000, 4'd10}, // R10 other page untouched
        {1'b1, 6'h0E, 16'h1234, 6'h0E, 16'h1234, 4'd10}, // R10 last banked word
        {1'b1, 6'h02, 16'h0003, 6'h08, 16'hA5A5, 4'd10}, // R10 back to page 3
        {1'b0, 6'h00, 16'h0000, 6'h00, 16'h4850, 4'd2},  // R2 ID on page 3
        {1'b1, 6'h04, 16'h0047, 6'h04, 16'h0046, 4'd5},  // R5 low-byte set
        {1'b1, 6'h04, 16'h2100, 6'h04, 16'h2046, 4'd5},  // R5 high-byte set
        {1'b1, 6'h04, 16'h0004, 6'h04, 16'h2042, 4'd5},  // R5 low-byte clear
        {1'b1, 6'h04, 16'h2000, 6'h04, 16'h0042, 4'd5},  // R5 high-byte clear
        {1'b1, 6'h02, 16'h000F, 6'h02, 16'h5377, 4'd3},  // R3 bit 3 dropped
        {1'b0, 6'h00, 16'h0000, 6'h04, 16'h0042, 4'd4},  // R4 option on page 7
        {1'b1, 6'h00, 16'hFFFF, 6'h00, 16'h4850, 4'd4},  // R4 trace write keeps ID
        {1'b0, 6'h00, 16'h0000, 6'h10, 16'h0000, 4'd11}, // R11 above bank
        {1'b0, 6'h00, 16'h0000, 6'h05, 16'h0000, 4'd11}, // R11 odd offset
        {1'b1, 6'h06, 16'h0080, 6'h06, 16'h0080, 4'd12}  // R12 priority bit
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_word(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a, input logic [15:0] exp);
        host_addr = a;
        #2;
        check(tag, host_rdata, exp);
    endtask

    initial begin
        #(20ns * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_check("R1 page word", 6'h02, 16'h5370);
        rd_check("R1 option word", 6'h04, 16'h0000);
        rd_check("R1 command word", 6'h06, 16'h0000);
        check("R1 outputs", 16'({ctrl_reset_n, ctrl_reset_pulse, mmap_active,
                                 adv_req, tx_req, ee_busy}), 16'h0000);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][48]) wr_word(VEC[i][47:42], VEC[i][41:26]);
            rd_check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][25:20], VEC[i][19:4]);
        end

        // R2 trace port
        @(negedge clk);
        host_wr = 1'b1; host_addr = 6'h00; host_wdata = 16'hBEEF;
        #2;
        check("R2 trace valid", 16'(trace_valid), 16'h0001);
        check("R2 trace data", trace_data, 16'hBEEF);
        @(negedge clk);
        host_wr = 1'b0;
        #2;
        check("R2 trace idle", 16'(trace_valid), 16'h0000);

        // R6 reset release pulse
        wr_word(6'h04, 16'h0002);
        check("R6 held in reset", 16'({ctrl_reset_n, ctrl_reset_pulse}), 16'h0000);
        wr_word(6'h04, 16'h0003);
        check("R6 pulse", 16'({ctrl_reset_n, ctrl_reset_pulse}), 16'h0003);
        @(negedge clk);
        check("R6 pulse ends", 16'({ctrl_reset_n, ctrl_reset_pulse}), 16'h0002);

        // R7 memory map enable
        check("R7 enabled", 16'(mmap_active), 16'h0001);
        wr_word(6'h04, 16'h2100);
        check("R7 map disabled", 16'(mmap_active), 16'h0000);
        wr_word(6'h04, 16'h2000);
        check("R7 re-enabled", 16'(mmap_active), 16'h0001);
        wr_word(6'h04, 16'h0040);
        check("R7 memory off", 16'(mmap_active), 16'h0000);

        // R8 self-clearing commands
        wr_word(6'h06, 16'h0086);
        rd_check("R8 both set", 6'h06, 16'h0086);
        check("R8 req outputs", 16'({adv_req, tx_req}), 16'h0003);
        wr_word(6'h06, 16'h0080);
        rd_check("R8 zero write ignored", 6'h06, 16'h0086);
        @(negedge clk); tx_done = 1'b1;
        @(negedge clk); tx_done = 1'b0;
        rd_check("R8 tx cleared", 6'h06, 16'h0084);
        check("R8 tx_req", 16'({adv_req, tx_req}), 16'h0002);
        @(negedge clk); adv_done = 1'b1;
        @(negedge clk); adv_done = 1'b0;
        rd_check("R8 adv cleared", 6'h06, 16'h0080);

        // R9 EEPROM load window, with a restart attempt mid-load
        wr_word(6'h06, 16'h00C0);
        rd_check("R9 busy bit", 6'h06, 16'h00C0);
        begin
            int n = 0;
            while (ee_busy && n < 4 * EE_N) begin
                n++;
                host_wr    = (n == 5);
                host_addr  = 6'h06;
                host_wdata = 16'h00C0;
                @(negedge clk);
            end
            host_wr = 1'b0;
            check("R9 busy length", 16'(n), 16'(EE_N));
        end
        rd_check("R9 done", 6'h06, 16'h0080);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule